// File: doc/BRIEF.md
# Line Violation Policy Learner

This block keeps one small record per speculatively tracked memory line and uses it to learn how that line has caused cross-thread dependence violations. From that history it picks the squash-avoidance policy to use on later accesses to the line. The policy is one of five: plain speculation, delayed disambiguation, value prediction, stall-until-release, or stall-until-non-speculative. The records sit at the same index as the line's disambiguation-table entry, so the surrounding logic addresses both tables with one index.

The block receives one line event per cycle: a potential violation, a squash, a squash-avoided notice, or a release that frees the entry. It also receives a pulse for each thread commit. Squashes counted under the current policy escalate the line to more conservative handling when they reach programmable thresholds. After a programmable number of commits, every tracked line steps back one level. A line skips that step if its current policy has saved a squash since the last aging pass. Carrying out the chosen policy is done elsewhere. The block only answers policy reads, which return one cycle after the request.

Top module: `line_policy_learner`

## Requirements
- R1: After reset, and for any entry that is not in use, a read returns plain speculation. Policy codes on `pol_o` are 0 plain, 1 delayed disambiguation, 2 value prediction, 3 stall-until-release and 4 stall-until-non-speculative, and no other value appears.
- R2: A potential-violation event (kind 0) or a squash event (kind 1) on a line in plain speculation moves the line to its first speculative policy with a zero squash count. That policy is code 1 when `first_vp_i` is 0 and code 2 when it is 1.
- R3: Under policy 1 or 2, each squash adds one to the line's count. The squash that brings the count to `thr_release_i` moves the line to policy 3.
- R4: The squash count restarts from zero whenever the line's policy changes, so the escalation thresholds count only squashes seen under the current policy.
- R5: Under policy 3, the squash that brings the count to `thr_wait_i` moves the line to policy 4.
- R6: Under policy 4, further squashes leave the policy at 4.
- R7: A squash-avoided event (kind 2) on a line under a speculative policy marks the line as having saved a squash and does not change its policy.
- R8: Each time `age_period_i` commits have been counted, every line in use steps down one level (4 to 3, 3 to 1, 2 to 1, 1 to 0) unless its saved mark is set. The saved mark is cleared on every line at that pass. The pass starts on the cycle after the commit that completes the period and visits one entry per cycle.
- R9: With `age_period_i` at 0, commits never age any line.
- R10: A potential-violation event on a line already under a speculative policy leaves its policy unchanged.
- R11: A release event (kind 3) returns the line to plain speculation.
- R12: `pol_valid_o` is high exactly one cycle after `rd_req_i`. `pol_o` then holds the line's policy as it stood before any event applied at that same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_valid_i | input | 1 | A line event is presented this cycle |
| ev_kind_i | input | 2 | Event kind: 0 potential violation, 1 squash, 2 squash avoided, 3 release |
| ev_idx_i | input | IDX_W | Entry index of the event |
| commit_i | input | 1 | One thread commit this cycle |
| first_vp_i | input | 1 | First speculative policy: 0 delayed disambiguation, 1 value prediction |
| thr_release_i | input | CNT_W | Squashes that escalate to stall-until-release |
| thr_wait_i | input | CNT_W | Squashes that escalate to stall-until-non-speculative |
| age_period_i | input | AGE_W | Commits per aging pass, 0 disables aging |
| rd_req_i | input | 1 | Policy read request |
| rd_idx_i | input | IDX_W | Entry index to read |
| pol_valid_o | output | 1 | Read response valid |
| pol_o | output | 3 | Policy code of the entry read |

## Verification
The hardest state to reach is aging that is held back: a line that saved a squash must survive one aging pass unchanged and then drop on the next. Showing this takes two full commit periods with the mark set in between, so the stimulus raises a line to a stall policy, records an avoided squash, and then sends two complete periods of commit pulses. The line is read after each pass finishes. A second hard point is the counter restart after a policy change. It is reached by aging a line down from a stall policy and then counting squashes again against the release threshold.

// File: rtl/lvp_pkg.sv
package lvp_pkg;

  typedef enum logic [2:0] {
    POL_PLAIN = 3'd0,
    POL_DELAY = 3'd1,
    POL_VPRED = 3'd2,
    POL_STALL_REL = 3'd3,
    POL_STALL_WAIT = 3'd4
  } pol_e;

  typedef enum logic [1:0] {
    EV_POT_VIOL = 2'd0,
    EV_SQUASH   = 2'd1,
    EV_AVOIDED  = 2'd2,
    EV_RELEASE  = 2'd3
  } ev_kind_e;

  function automatic pol_e pol_down(pol_e p);
    case (p)
      POL_STALL_WAIT: return POL_STALL_REL;
      POL_STALL_REL:  return POL_DELAY;
      POL_VPRED:      return POL_DELAY;
      default:        return POL_PLAIN;
    endcase
  endfunction

endpackage

// File: rtl/lvp_event_fsm.sv
module lvp_event_fsm
  import lvp_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             valid_i,
  input  pol_e             pol_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             saved_i,
  input  ev_kind_e         kind_i,
  input  logic             first_vp_i,
  input  logic [CNT_W-1:0] thr_rel_i,
  input  logic [CNT_W-1:0] thr_wait_i,
  output logic             valid_o,
  output pol_e             pol_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             saved_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_inc;
  logic             is_plain;
  pol_e             first_pol;

  assign cnt_inc   = (cnt_i == CNT_MAX) ? cnt_i : cnt_i + 1'b1;
  assign is_plain  = !valid_i || (pol_i == POL_PLAIN);
  assign first_pol = first_vp_i ? POL_VPRED : POL_DELAY;

  always_comb begin
    valid_o = valid_i;
    pol_o   = is_plain ? POL_PLAIN : pol_i;
    cnt_o   = cnt_i;
    saved_o = saved_i;
    unique case (kind_i)
      EV_RELEASE: begin
        valid_o = 1'b0;
        pol_o   = POL_PLAIN;
        cnt_o   = '0;
        saved_o = 1'b0;
      end
      EV_AVOIDED: begin
        if (!is_plain) saved_o = 1'b1;
      end
      EV_POT_VIOL: begin
        if (is_plain) begin
          valid_o = 1'b1;
          pol_o   = first_pol;
          cnt_o   = '0;
          saved_o = 1'b0;
        end
      end
      EV_SQUASH: begin
        if (is_plain) begin
          valid_o = 1'b1;
          pol_o   = first_pol;
          cnt_o   = '0;
          saved_o = 1'b0;
        end else begin
          case (pol_i)
            POL_DELAY, POL_VPRED: begin
              if (cnt_inc >= thr_rel_i) begin
                pol_o   = POL_STALL_REL;
                cnt_o   = '0;
                saved_o = 1'b0;
              end else begin
                cnt_o = cnt_inc;
              end
            end
            POL_STALL_REL: begin
              if (cnt_inc >= thr_wait_i) begin
                pol_o   = POL_STALL_WAIT;
                cnt_o   = '0;
                saved_o = 1'b0;
              end else begin
                cnt_o = cnt_inc;
              end
            end
            default: cnt_o = cnt_inc;
          endcase
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/lvp_age_step.sv
module lvp_age_step
  import lvp_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             valid_i,
  input  pol_e             pol_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             saved_i,
  output pol_e             pol_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             saved_o
);

  always_comb begin
    pol_o   = pol_i;
    cnt_o   = cnt_i;
    saved_o = 1'b0;
    if (valid_i && !saved_i && pol_i != POL_PLAIN) begin
      pol_o = pol_down(pol_i);
      cnt_o = '0;
    end
  end

endmodule

// File: rtl/lvp_age_sweep.sv
module lvp_age_sweep #(
  parameter int N_ENTRIES = 2048,
  parameter int AGE_W     = 16,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             commit_i,
  input  logic [AGE_W-1:0] age_period_i,
  input  logic             stall_i,
  output logic             go_o,
  output logic [IDX_W-1:0] ptr_o
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENTRIES - 1);

  logic [AGE_W-1:0] commit_cnt_q;
  logic             active_q, pend_q;
  logic [IDX_W-1:0] ptr_q;
  logic             period_done;

  assign period_done = commit_i && (age_period_i != '0)
                       && (commit_cnt_q + 1'b1 >= age_period_i);
  assign go_o  = active_q && !stall_i;
  assign ptr_o = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      commit_cnt_q <= '0;
      active_q     <= 1'b0;
      pend_q       <= 1'b0;
      ptr_q        <= '0;
    end else begin
      if (age_period_i == '0) commit_cnt_q <= '0;
      else if (period_done)   commit_cnt_q <= '0;
      else if (commit_i)      commit_cnt_q <= commit_cnt_q + 1'b1;

      if (go_o) begin
        if (ptr_q == LAST) begin
          ptr_q    <= '0;
          active_q <= pend_q || period_done;
          pend_q   <= 1'b0;
        end else begin
          ptr_q <= ptr_q + 1'b1;
          if (period_done) pend_q <= 1'b1;
        end
      end else if (period_done) begin
        if (active_q) pend_q <= 1'b1;
        else begin
          active_q <= 1'b1;
          ptr_q    <= '0;
        end
      end
    end
  end

  p_ptr_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_o |-> (ptr_o <= LAST));

  p_age_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_period_i == '0 && !active_q && !pend_q) |=> !active_q);

endmodule

// File: rtl/lvp_table.sv
module lvp_table
  import lvp_pkg::*;
#(
  parameter int N_ENTRIES = 2048,
  parameter int CNT_W     = 4,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  // event-side combinational read
  input  logic [IDX_W-1:0] ea_idx_i,
  output logic             ea_valid_o,
  output pol_e             ea_pol_o,
  output logic [CNT_W-1:0] ea_cnt_o,
  output logic             ea_saved_o,
  // sweep-side combinational read
  input  logic [IDX_W-1:0] sa_idx_i,
  output logic             sa_valid_o,
  output pol_e             sa_pol_o,
  output logic [CNT_W-1:0] sa_cnt_o,
  output logic             sa_saved_o,
  // event write
  input  logic             ew_en_i,
  input  logic             ew_valid_i,
  input  pol_e             ew_pol_i,
  input  logic [CNT_W-1:0] ew_cnt_i,
  input  logic             ew_saved_i,
  // sweep write
  input  logic             sw_en_i,
  input  pol_e             sw_pol_i,
  input  logic [CNT_W-1:0] sw_cnt_i,
  input  logic             sw_saved_i,
  // registered read port
  input  logic             rd_req_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_valid_o,
  output logic [2:0]       rd_pol_o
);

  logic             valid_q [N_ENTRIES];
  pol_e             pol_q   [N_ENTRIES];
  logic [CNT_W-1:0] cnt_q   [N_ENTRIES];
  logic             saved_q [N_ENTRIES];

  assign ea_valid_o = valid_q[ea_idx_i];
  assign ea_pol_o   = pol_q[ea_idx_i];
  assign ea_cnt_o   = cnt_q[ea_idx_i];
  assign ea_saved_o = saved_q[ea_idx_i];
  assign sa_valid_o = valid_q[sa_idx_i];
  assign sa_pol_o   = pol_q[sa_idx_i];
  assign sa_cnt_o   = cnt_q[sa_idx_i];
  assign sa_saved_o = saved_q[sa_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_ENTRIES; i++) valid_q[i] <= 1'b0;
    end else if (ew_en_i) begin
      valid_q[ea_idx_i] <= ew_valid_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (ew_en_i) begin
      pol_q[ea_idx_i]   <= ew_pol_i;
      cnt_q[ea_idx_i]   <= ew_cnt_i;
      saved_q[ea_idx_i] <= ew_saved_i;
    end
    if (sw_en_i) begin
      pol_q[sa_idx_i]   <= sw_pol_i;
      cnt_q[sa_idx_i]   <= sw_cnt_i;
      saved_q[sa_idx_i] <= sw_saved_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_pol_o   <= 3'd0;
    end else begin
      rd_valid_o <= rd_req_i;
      if (rd_req_i) rd_pol_o <= valid_q[rd_idx_i] ? pol_q[rd_idx_i] : POL_PLAIN;
    end
  end

  p_read_latency_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_i |=> rd_valid_o);

  p_pol_legal_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> (rd_pol_o <= 3'd4));

endmodule

// File: rtl/line_policy_learner.sv
module line_policy_learner
  import lvp_pkg::*;
#(
  parameter int N_ENTRIES = 2048,
  parameter int CNT_W     = 4,
  parameter int AGE_W     = 16,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ev_valid_i,
  input  logic [1:0]       ev_kind_i,
  input  logic [IDX_W-1:0] ev_idx_i,
  input  logic             commit_i,
  input  logic             first_vp_i,
  input  logic [CNT_W-1:0] thr_release_i,
  input  logic [CNT_W-1:0] thr_wait_i,
  input  logic [AGE_W-1:0] age_period_i,
  input  logic             rd_req_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             pol_valid_o,
  output logic [2:0]       pol_o
);

  ev_kind_e         kind;
  logic             cur_valid, cur_saved, nxt_valid, nxt_saved;
  pol_e             cur_pol, cur_pol_eff, nxt_pol;
  logic [CNT_W-1:0] cur_cnt, nxt_cnt;

  logic             sw_go;
  logic [IDX_W-1:0] sw_ptr;
  logic             sa_valid, sa_saved, age_saved;
  pol_e             sa_pol, age_pol;
  logic [CNT_W-1:0] sa_cnt, age_cnt;

  assign kind        = ev_kind_e'(ev_kind_i);
  assign cur_pol_eff = cur_valid ? cur_pol : POL_PLAIN;

  lvp_event_fsm #(.CNT_W(CNT_W)) i_event_fsm (
    .valid_i    (cur_valid),
    .pol_i      (cur_pol),
    .cnt_i      (cur_cnt),
    .saved_i    (cur_saved),
    .kind_i     (kind),
    .first_vp_i (first_vp_i),
    .thr_rel_i  (thr_release_i),
    .thr_wait_i (thr_wait_i),
    .valid_o    (nxt_valid),
    .pol_o      (nxt_pol),
    .cnt_o      (nxt_cnt),
    .saved_o    (nxt_saved)
  );

  // events win over the sweep on the same entry; the sweep waits one cycle
  lvp_age_sweep #(.N_ENTRIES(N_ENTRIES), .AGE_W(AGE_W)) i_age_sweep (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .commit_i     (commit_i),
    .age_period_i (age_period_i),
    .stall_i      (ev_valid_i && (ev_idx_i == sw_ptr)),
    .go_o         (sw_go),
    .ptr_o        (sw_ptr)
  );

  lvp_age_step #(.CNT_W(CNT_W)) i_age_step (
    .valid_i (sa_valid),
    .pol_i   (sa_pol),
    .cnt_i   (sa_cnt),
    .saved_i (sa_saved),
    .pol_o   (age_pol),
    .cnt_o   (age_cnt),
    .saved_o (age_saved)
  );

  lvp_table #(.N_ENTRIES(N_ENTRIES), .CNT_W(CNT_W)) i_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ea_idx_i   (ev_idx_i),
    .ea_valid_o (cur_valid),
    .ea_pol_o   (cur_pol),
    .ea_cnt_o   (cur_cnt),
    .ea_saved_o (cur_saved),
    .sa_idx_i   (sw_ptr),
    .sa_valid_o (sa_valid),
    .sa_pol_o   (sa_pol),
    .sa_cnt_o   (sa_cnt),
    .sa_saved_o (sa_saved),
    .ew_en_i    (ev_valid_i),
    .ew_valid_i (nxt_valid),
    .ew_pol_i   (nxt_pol),
    .ew_cnt_i   (nxt_cnt),
    .ew_saved_i (nxt_saved),
    .sw_en_i    (sw_go),
    .sw_pol_i   (age_pol),
    .sw_cnt_i   (age_cnt),
    .sw_saved_i (age_saved),
    .rd_req_i   (rd_req_i),
    .rd_idx_i   (rd_idx_i),
    .rd_valid_o (pol_valid_o),
    .rd_pol_o   (pol_o)
  );

  p_cnt_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_i && nxt_pol != cur_pol_eff) |-> (nxt_cnt == '0));

  p_escalate_only_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_i && kind != EV_RELEASE) |-> (nxt_pol >= cur_pol_eff));

  p_pv_no_effect_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_i && kind == EV_POT_VIOL && cur_pol_eff != POL_PLAIN)
      |-> (nxt_pol == cur_pol_eff));

  p_age_clears_saved_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_go |-> !age_saved);

  p_release_plain_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_i && kind == EV_RELEASE) |-> (!nxt_valid && nxt_pol == POL_PLAIN));

endmodule

// File: tb/test_line_policy_learner.sv
module test_line_policy_learner;

  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int CW = 4;
  localparam int AW = 8;
  localparam int IW = $clog2(N);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          ev_valid_i = 1'b0;
  logic [1:0]    ev_kind_i = '0;
  logic [IW-1:0] ev_idx_i = '0;
  logic          commit_i = 1'b0;
  logic          first_vp_i = 1'b0;
  logic [CW-1:0] thr_release_i = CW'(3);
  logic [CW-1:0] thr_wait_i = CW'(2);
  logic [AW-1:0] age_period_i = AW'(4);
  logic          rd_req_i = 1'b0;
  logic [IW-1:0] rd_idx_i = '0;
  logic          pol_valid_o;
  logic [2:0]    pol_o;

  int n_checks = 0;
  int n_fail   = 0;
  int exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  line_policy_learner #(.N_ENTRIES(N), .CNT_W(CW), .AGE_W(AW)) i_line_policy_learner (
    .clk_i, .rst_ni, .ev_valid_i, .ev_kind_i, .ev_idx_i, .commit_i, .first_vp_i,
    .thr_release_i, .thr_wait_i, .age_period_i, .rd_req_i, .rd_idx_i,
    .pol_valid_o, .pol_o
  );

  // kind codes: 0 potential violation, 1 squash, 2 avoided, 3 release
  // policy codes: 0 plain, 1 delay, 2 value pred, 3 stall-release, 4 stall-wait

  always @(negedge clk_i) begin
    if (rst_ni && pol_valid_o) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R12 unexpected response: actual=%0d expected=none", pol_o);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (int'(pol_o) != e) begin
          n_fail++;
          $display("FAIL %s actual=%0d expected=%0d", t, pol_o, e);
        end
      end
    end
  end

  task automatic ev(input int kind, input int idx);
    @(negedge clk_i);
    ev_valid_i = 1'b1; ev_kind_i = 2'(kind); ev_idx_i = IW'(idx);
    @(negedge clk_i);
    ev_valid_i = 1'b0;
  endtask

  task automatic query(input int idx, input int exp, input string tag);
    @(negedge clk_i);
    rd_req_i = 1'b1; rd_idx_i = IW'(idx);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk_i);
    rd_req_i = 1'b0;
  endtask

  task automatic commits(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); commit_i = 1'b1;
      @(negedge clk_i); commit_i = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic finish_run();
    idle(4);
    if (exp_q.size() != 0) begin
      n_checks++; n_fail++;
      $display("FAIL R12 missing responses: actual=0 expected=%0d", exp_q.size());
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(2);
    query(0, 0, "R1 reset plain");
    query(7, 0, "R1 reset plain top index");

    ev(0, 1);
    query(1, 1, "R2 first violation to delay");
    ev(1, 1); ev(1, 1);
    query(1, 1, "R3 below release threshold");
    ev(1, 1);
    query(1, 3, "R3 release threshold reached");
    ev(1, 1);
    query(1, 3, "R4 count restarted under stall-release");
    ev(1, 1);
    query(1, 4, "R5 wait threshold reached");
    ev(1, 1); ev(1, 1);
    query(1, 4, "R6 stall-wait saturates");
    ev(0, 1);
    query(1, 4, "R10 violation on speculative line ignored");

    ev(1, 3);
    query(3, 1, "R2 squash on plain line");
    first_vp_i = 1'b1;
    ev(0, 2);
    first_vp_i = 1'b0;
    query(2, 2, "R2 first policy value predict");

    // same-edge read and event
    @(negedge clk_i);
    ev_valid_i = 1'b1; ev_kind_i = 2'd0; ev_idx_i = IW'(5);
    rd_req_i = 1'b1; rd_idx_i = IW'(5);
    exp_q.push_back(0); tag_q.push_back("R12 read sees pre-event state");
    @(negedge clk_i);
    ev_valid_i = 1'b0; rd_req_i = 1'b0;
    query(5, 1, "R12 read after event");

    commits(3);
    idle(12);
    query(1, 4, "R8 no aging before period");
    commits(1);
    idle(12);
    query(1, 3, "R8 aged 4 to 3");
    query(2, 1, "R8 aged 2 to 1");
    query(3, 0, "R8 aged 1 to 0");
    query(0, 0, "R8 unused entry stays plain");

    ev(2, 1);
    query(1, 3, "R7 avoided keeps policy");
    commits(4);
    idle(12);
    query(1, 3, "R8 saved mark blocks aging");
    query(2, 0, "R8 unsaved line aged");
    commits(4);
    idle(12);
    query(1, 1, "R8 mark cleared then aged 3 to 1");

    ev(1, 1); ev(1, 1);
    query(1, 1, "R4 count restarted after aging");
    ev(1, 1);
    query(1, 3, "R4 threshold counted from zero");

    age_period_i = '0;
    commits(10);
    idle(12);
    query(1, 3, "R9 aging disabled");

    ev(3, 1);
    query(1, 0, "R11 release to plain");
    ev(2, 1);
    query(1, 0, "R7 avoided on plain line no effect");

    finish_run();
  end

endmodule